// File: doc/BRIEF.md
# Four-Channel Sequential Successive-Approximation Conversion Controller

This controller drives the digital half of a four-input data acquisition front end. An external start line, which has no fixed phase relation to the converter clock, is brought into the clock domain. Its rising edge places all four track/hold stages in hold. The controller then digitises the four held voltages one after another, always in the order channel 0, 1, 2, 3. For each channel it runs a 12-bit binary search. In every trial cycle it presents a channel select and a DAC code word, and it reads back one comparator bit. Each finished result goes into a register for that channel, in two's-complement form. An active-low interrupt then tells the readout logic that all four values are ready.

The state machine has six states. ST_IDLE is the state after reset. Each channel passes through ST_GAP (fixed padding), ST_SETTLE (one cycle for the DAC and comparator to settle), ST_TRIAL (twelve bit decisions) and ST_STORE (result written). ST_DONE holds the interrupt low. The transitions are:
- ST_IDLE or ST_DONE to ST_GAP on an accepted start.
- ST_GAP to ST_SETTLE when the padding count expires.
- ST_SETTLE to ST_TRIAL unconditionally.
- ST_TRIAL to ST_STORE after the least significant trial.
- ST_STORE to ST_GAP of the next channel, or to ST_DONE after the last channel.

A synchronous reset from any state returns to ST_IDLE. Each channel slot lasts exactly 19 clock cycles. The total time from start to interrupt is therefore fixed for a given clock phase of the start edge.

Top module: `quad_sar_sequencer`

## Requirements
- R1: While reset is held, and after it is released with start low, irq_n_o is 1, hold_o is 0 and every result field reads 0.
- R2: The start input passes through two synchroniser flops and a rising-edge detector. Call the first rising clock edge that samples start high edge C. irq_n_o falls on edge C+78, which means 78 edges after the capturing edge, or 79 edges from start when capture slips by one edge.
- R3: hold_o goes high in the same instant as start rises. It stays high until the edge at which irq_n_o falls. After that edge, with start low, it is 0.
- R4: Channels are converted in the order 0, 1, 2, 3. Each uses a 19-cycle slot, and sel_o shows the channel number. The result of channel k appears in result_o[12k+11:12k] at edge C+21+19k. It is therefore written before the next channel's slot begins.
- R5: The search works in offset binary, MSB first. The first trial of each channel shows dac_code_o = 0x800, at edge C+8+19k. A trial bit is kept when cmp_i = 1 (DAC value not above the input). The next trial shows the kept bits with the next lower bit set.
- R6: A stored result is the offset-binary search result with the MSB inverted, which gives two's complement. An input half an LSB below zero gives 0xFFF, zero gives 0x000, the top of the range gives 0x7FF and the bottom gives 0x800.
- R7: A start rise that arrives while a sequence is running is ignored. This includes one whose detected edge falls in the cycle of the last channel's store. Such a rise changes neither the timing nor the results, and it does not start a later sequence.
- R8: irq_n_o stays low after completion until the next accepted start. A start detected in the cycle just after completion is accepted, and irq_n_o returns high at edge C'+2 of that start.
- R9: Asserting reset during a conversion aborts it. irq_n_o goes to 1, the results go to 0, and no sequence runs after release without a new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Converter clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Asynchronous start; a rising edge begins a sequence |
| cmp_i | input | 1 | Comparator bit: 1 when the DAC value does not exceed the held input |
| hold_o | output | 1 | Track/hold control for all four stages, 1 = hold |
| sel_o | output | 2 | Channel being converted |
| dac_code_o | output | 12 | Offset-binary trial code for the DAC |
| result_o | output | 48 | Four two's-complement results, channel k in bits 12k+11:12k |
| irq_n_o | output | 1 | Active-low sequence-complete interrupt |

## Verification
Two things can happen in the same cycle: detection of a new start edge, and the last channel's store that completes the sequence. The bench raises start half a cycle after edge C+75, so that the detected pulse coincides with the ST_STORE cycle of channel 3. It then expects the interrupt to fall on time and to stay low 30 cycles later, with no second sequence. A separate run raises start one cycle later, so that the detection lands in the first ST_DONE cycle. There the bench expects the sequence to be accepted: the interrupt rises two edges after capture, and a full set of results follows at the computed edges.

// File: rtl/sarq_pkg.sv
package sarq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_SETTLE,
        ST_TRIAL,
        ST_STORE,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/sarq_start_sync.sv
module sarq_start_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_async_i,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], start_async_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;

    // R2: the detector emits a single-cycle pulse per edge
    a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o);

endmodule

// File: rtl/sarq_bit_search.sv
module sarq_bit_search #(
    parameter  int RES_W = 12,
    localparam int IDX_W = $clog2(RES_W)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [IDX_W-1:0] bit_idx_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] dac_code_o,
    output logic [RES_W-1:0] twos_o
);

    logic [RES_W-1:0] acc_q;
    logic [RES_W-1:0] trial_mask;

    assign trial_mask = RES_W'(1) << bit_idx_i;

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            acc_q <= '0;
        end else if (step_i) begin
            acc_q[bit_idx_i] <= cmp_i;
        end
    end

    assign dac_code_o = acc_q | trial_mask;
    assign twos_o     = {~acc_q[RES_W-1], acc_q[RES_W-2:0]};

    // R5: bits at and below the trial position are still clear when tried
    a_r5_lower_bits_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        step_i |-> ((acc_q & (trial_mask | (trial_mask - RES_W'(1)))) == '0));

    // R5: the decided bit equals the comparator verdict
    a_r5_bit_kept: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !clear_i) |=> (acc_q[$past(bit_idx_i)] == $past(cmp_i)));

endmodule

// File: rtl/sarq_result_bank.sv
module sarq_result_bank #(
    parameter  int N_CH  = 4,
    parameter  int RES_W = 12,
    localparam int CH_W  = $clog2(N_CH)
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  wr_i,
    input  logic [CH_W-1:0]       wr_ch_i,
    input  logic [RES_W-1:0]      wr_data_i,
    output logic [N_CH*RES_W-1:0] flat_o
);

    genvar g;
    generate
        for (g = 0; g < N_CH; g++) begin : g_slot
            logic [RES_W-1:0] val_q;
            logic             wen;

            assign wen = wr_i && (wr_ch_i == CH_W'(g));

            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    val_q <= '0;
                end else if (wen) begin
                    val_q <= wr_data_i;
                end
            end

            assign flat_o[g*RES_W +: RES_W] = val_q;
        end
    endgenerate

    // R4: results only change on a store cycle
    a_r4_write_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_i |=> $stable(flat_o));

endmodule

// File: rtl/quad_sar_sequencer.sv
module quad_sar_sequencer
    import sarq_pkg::*;
#(
    parameter  int RES_W       = 12,
    parameter  int N_CH        = 4,
    parameter  int GAP_CYC     = 5,
    parameter  int SYNC_STAGES = 2,
    localparam int CH_W        = $clog2(N_CH),
    localparam int IDX_W       = $clog2(RES_W),
    localparam int GAP_W       = $clog2(GAP_CYC + 1)
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  start_i,
    input  logic                  cmp_i,
    output logic                  hold_o,
    output logic [CH_W-1:0]       sel_o,
    output logic [RES_W-1:0]      dac_code_o,
    output logic [N_CH*RES_W-1:0] result_o,
    output logic                  irq_n_o
);

    localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(N_CH - 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);
    localparam logic [IDX_W-1:0] MSB_IDX  = IDX_W'(RES_W - 1);

    seq_state_t        state_q, state_d;
    logic [CH_W-1:0]   chan_q;
    logic [GAP_W-1:0]  gap_q;
    logic [IDX_W-1:0]  bit_q;
    logic              start_rise;
    logic              busy;
    logic              clr_acc;
    logic              step;
    logic              wr_res;
    logic [RES_W-1:0]  twos;

    sarq_start_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .start_async_i(start_i),
        .rise_o       (start_rise)
    );

    sarq_bit_search #(
        .RES_W(RES_W)
    ) u_search (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .clear_i   (clr_acc),
        .step_i    (step),
        .bit_idx_i (bit_q),
        .cmp_i     (cmp_i),
        .dac_code_o(dac_code_o),
        .twos_o    (twos)
    );

    sarq_result_bank #(
        .N_CH (N_CH),
        .RES_W(RES_W)
    ) u_bank (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .wr_i     (wr_res),
        .wr_ch_i  (chan_q),
        .wr_data_i(twos),
        .flat_o   (result_o)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (start_rise) state_d = ST_GAP;
            ST_GAP:           if (gap_q == GAP_LAST) state_d = ST_SETTLE;
            ST_SETTLE:        state_d = ST_TRIAL;
            ST_TRIAL:         if (bit_q == '0) state_d = ST_STORE;
            ST_STORE:         state_d = (chan_q == LAST_CH) ? ST_DONE : ST_GAP;
            default:          state_d = ST_IDLE;
        endcase
    end

    // state register with its slot counters
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            chan_q  <= '0;
            gap_q   <= '0;
            bit_q   <= MSB_IDX;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start_rise) begin
                        chan_q <= '0;
                        gap_q  <= '0;
                    end
                end
                ST_GAP: begin
                    gap_q <= gap_q + 1'b1;
                    bit_q <= MSB_IDX;
                end
                ST_SETTLE: ;
                ST_TRIAL: begin
                    if (bit_q != '0) bit_q <= bit_q - 1'b1;
                end
                ST_STORE: begin
                    gap_q <= '0;
                    if (chan_q != LAST_CH) chan_q <= chan_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        busy    = (state_q != ST_IDLE) && (state_q != ST_DONE);
        hold_o  = start_i | busy;
        irq_n_o = (state_q != ST_DONE);
        sel_o   = chan_q;
        clr_acc = (state_q == ST_GAP);
        step    = (state_q == ST_TRIAL);
        wr_res  = (state_q == ST_STORE);
    end

    // R2: the interrupt falls only right after the last channel's store
    a_r2_irq_after_last_store: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(irq_n_o) |-> ($past(state_q) == ST_STORE && $past(chan_q) == LAST_CH));

    // R3: hold was high up to the completion edge
    a_r3_hold_to_done: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(irq_n_o) |-> $past(hold_o));

    // R4: channel select does not move during a run of trials
    a_r4_sel_stable: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_TRIAL && $past(state_q) == ST_TRIAL) |-> $stable(sel_o));

    // R7: a start edge while busy never rewinds to channel 0
    a_r7_busy_ignores_start: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy && start_rise) |=> !(state_q == ST_GAP && gap_q == '0 && chan_q == '0));

    // R8: an accepted start after completion releases the interrupt
    a_r8_irq_released: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_DONE && start_rise) |=> irq_n_o);

endmodule

// File: tb/quad_sar_sequencer_bench.sv
module quad_sar_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        cmp_i;
    logic        hold_o;
    logic [1:0]  sel_o;
    logic [11:0] dac_code_o;
    logic [47:0] result_o;
    logic        irq_n_o;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int live2 [4];
    int held2 [4];

    typedef struct {
        int    due;
        int    kind;   // 0 result, 1 irq level, 2 dac code, 3 sel
        int    ch;
        int    expv;
        string tag;
    } item_t;

    item_t sb [$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    quad_sar_sequencer u_quad_sar_sequencer (
        .clk_i     (clk),
        .rst_i     (rst),
        .start_i   (start_i),
        .cmp_i     (cmp_i),
        .hold_o    (hold_o),
        .sel_o     (sel_o),
        .dac_code_o(dac_code_o),
        .result_o  (result_o),
        .irq_n_o   (irq_n_o)
    );

    // analog model: inputs in half-LSB offset units, latched when hold rises
    initial for (int i = 0; i < 4; i++) begin live2[i] = 0; held2[i] = 0; end
    always @(posedge hold_o) for (int i = 0; i < 4; i++) held2[i] = live2[i];
    always_comb cmp_i = ((2 * int'(dac_code_o)) <= held2[sel_o]);

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic void sb_add(input int due, input int kind, input int ch,
                                   input int expv, input string tag);
        item_t it;
        it.due = due; it.kind = kind; it.ch = ch; it.expv = expv; it.tag = tag;
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].due > due) begin
                sb.insert(i, it);
                return;
            end
        end
        sb.push_back(it);
    endfunction

    // driver: sets inputs, raises start at a negedge, pushes expectations
    task automatic launch(input int v0, input int v1, input int v2, input int v3,
                          input bit push, output int cap);
        int vv [4];
        vv = '{v0, v1, v2, v3};
        @(negedge clk);
        for (int i = 0; i < 4; i++) live2[i] = vv[i];
        @(negedge clk);
        start_i = 1'b1;
        cap = cyc + 1;
        if (push) begin
            sb_add(cap + 2, 1, 0, 1, "R8 irq released at start");
            for (int k = 0; k < 4; k++) begin
                int off;
                off = vv[k] / 2;
                sb_add(cap + 8 + 19*k, 3, 0, k, "R4 channel order");
                sb_add(cap + 8 + 19*k, 2, 0, 'h800, "R5 first trial code");
                sb_add(cap + 9 + 19*k, 2, 0, (off & 'h800) | 'h400, "R5 second trial code");
                sb_add(cap + 21 + 19*k, 0, k, (off ^ 'h800) & 'hFFF, "R4/R6 stored result");
            end
            sb_add(cap + 77, 1, 0, 1, "R2 irq high before final edge");
            sb_add(cap + 78, 1, 0, 0, "R2 irq low at final edge");
        end
        repeat (4) @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // monitor: compares scoreboard items when they fall due
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            if (it.due < cyc) begin
                check({it.tag, " (missed)"}, 0, 1);
            end else begin
                case (it.kind)
                    0: check(it.tag, int'(result_o[it.ch*12 +: 12]), it.expv);
                    1: check(it.tag, int'(irq_n_o), it.expv);
                    2: check(it.tag, int'(dac_code_o), it.expv);
                    default: check(it.tag, int'(sel_o), it.expv);
                endcase
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        int c;
        int c2;
        repeat (3) @(negedge clk);
        check("R1 irq during reset", int'(irq_n_o), 1);
        check("R1 hold during reset", int'(hold_o), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 irq after reset", int'(irq_n_o), 1);
        check("R1 hold after reset", int'(hold_o), 0);
        check("R1 results after reset", (result_o == '0) ? 1 : 0, 1);

        // boundary codes: -1/2 LSB, zero, top, bottom (R6)
        launch(4095, 4096, 8191, 0, 1'b1, c);
        wait_until(c + 30);
        check("R3 hold mid conversion", int'(hold_o), 1);
        wait_until(c + 77);
        check("R3 hold before completion", int'(hold_o), 1);
        wait_until(c + 79);
        check("R3 hold after completion", int'(hold_o), 0);
        check("R8 irq stays low", int'(irq_n_o), 0);

        // live inputs move after hold; a second start arrives mid-run (R3, R7)
        launch(5000, 1234, 7777, 3001, 1'b1, c);
        wait_until(c + 10);
        for (int i = 0; i < 4; i++) live2[i] = 8000 - 100*i;
        wait_until(c + 30);
        start_i = 1'b1;
        repeat (2) @(negedge clk);
        start_i = 1'b0;
        wait_until(c + 85);

        // start detected in the final store cycle is ignored (R7)
        launch(100, 200, 300, 400, 1'b1, c);
        wait_until(c + 75);
        start_i = 1'b1;
        repeat (2) @(negedge clk);
        start_i = 1'b0;
        sb_add(c + 110, 1, 0, 0, "R7 no sequence from store-cycle start");
        wait_until(c + 115);

        // start detected in the first done cycle is accepted (R8)
        launch(6000, 2000, 4500, 3500, 1'b1, c);
        wait_until(c + 74);
        launch(6000, 2000, 4500, 3500, 1'b1, c2);
        check("R8 back-to-back capture edge", c2 - c, 77);
        wait_until(c2 + 85);

        // reset in mid-conversion aborts (R9)
        launch(1000, 2000, 3000, 4000, 1'b0, c);
        wait_until(c + 30);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R9 irq after abort", int'(irq_n_o), 1);
        check("R9 hold after abort", int'(hold_o), 0);
        check("R9 results cleared", (result_o == '0) ? 1 : 0, 1);
        repeat (100) @(negedge clk);
        check("R9 no sequence after abort", int'(irq_n_o), 1);

        // fresh run after abort, codes adjacent to the mid-scale boundary
        launch(4097, 4094, 1, 8190, 1'b1, c);
        wait_until(c + 85);

        while (sb.size() > 0) @(negedge clk);
        finish_run();
    end

endmodule